// File: doc/BRIEF.md
# Sector Read Execution Engine

This block carries out the execution phase of a single sector read in a floppy-style disk controller. A command is launched with a one-cycle start strobe. The start strobe presents the target sector number, the sector size code, the short-sector transfer length and two option bits taken from the first command byte: the recording density (MFM or FM) and the skip-deleted option. The engine then watches a pre-decoded stream from the read channel. That stream carries ID field records with a CRC verdict, data field start markers flagged as normal or deleted, data bytes, data field end markers with a CRC verdict, and index pulses.

When an ID record's sector number equals the target, the following data field is transferred. Each byte goes to a single-byte host holding register, and the host drains that register with an acknowledge strobe. Every byte placed there starts a service deadline, and an acknowledge reloads it. The deadline is 27 µs in FM mode and 13 µs in MFM mode, counted in clock cycles derived from the clock frequency parameter. The read channel supplies data bytes slower than the deadline, so the holding register is always free when the next byte arrives unless an overrun has already ended the command.

When the command terminates, the engine raises a one-cycle done pulse and presents three status bytes. These stay valid until the next termination. MFM/FM decoding, CRC computation and drive mechanics belong to other blocks.

Top module: `sector_read_engine`

## Requirements
- R1: After reset, busy, done and host_valid are 0 and st0, st1 and st2 are 0x00. While busy is 0, host_valid stays 0.
- R2: Only the data field that follows an ID record whose sector number equals the target is forwarded. Data of fields after non-matching IDs is not forwarded. Bytes reach host_data in arrival order. A clean sector ends with st0 = 0x00, st1 = 0x00 and st2 = 0x00.
- R3: With size code 0, only the first DTL bytes of the data field are forwarded. The field's CRC verdict is still evaluated at its end.
- R4: With a nonzero size code, DTL has no effect and every byte of the field is forwarded.
- R5: If a second index pulse arrives while searching without a matching ID, the command ends with st1 bit 2 (no data) set. A single index pulse does not end the search.
- R6: An ID record with a failed CRC ends the command with st1 bit 5 (data error) set and st2 = 0x00.
- R7: A data field with a failed CRC ends the command with st1 bit 5 and st2 bit 5 (error in data field) set.
- R8: A deleted data field read with the skip option clear is forwarded in full. The command then ends with st2 bit 6 (control mark) set.
- R9: A deleted data field read with the skip option set is not forwarded and its CRC verdict is ignored. The target sector number is incremented and the search continues for that next sector.
- R10: If a forwarded byte is not acknowledged within 13 cycles per µs of clock in MFM mode, or 27 in FM mode, the command ends with st1 bit 4 (overrun) set. An acknowledge on the last allowed cycle is in time.
- R11: Every termination gives exactly one done pulse of one cycle. st0 bits 7:6 are 01 when any flag in st1 or st2 is set, and 00 otherwise. All other st0 bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_start | input | 1 | Command launch strobe, accepted when idle |
| cmd_mfm | input | 1 | 1 = MFM density, 0 = FM density |
| cmd_skip | input | 1 | Skip-deleted option from the first command byte |
| cmd_r | input | 8 | Target sector number |
| cmd_n | input | 3 | Sector size code |
| cmd_dtl | input | 8 | Transfer length used when the size code is 0 |
| idx_pulse | input | 1 | Index hole strobe |
| id_valid | input | 1 | ID record strobe |
| id_r | input | 8 | Sector number of the ID record |
| id_crc_ok | input | 1 | CRC verdict of the ID record |
| dat_start | input | 1 | Data field start strobe |
| dat_deleted | input | 1 | Data field carries a deleted address mark |
| dat_byte_valid | input | 1 | Data byte strobe |
| dat_byte | input | 8 | Data byte |
| dat_end | input | 1 | Data field end strobe |
| dat_crc_ok | input | 1 | CRC verdict of the data field |
| host_valid | output | 1 | Host holding register full |
| host_data | output | 8 | Host holding register contents |
| host_ack | input | 1 | Host takes the byte |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle termination pulse |
| st0 | output | 8 | Status byte 0 |
| st1 | output | 8 | Status byte 1 |
| st2 | output | 8 | Status byte 2 |

## Verification
A stuck or wrong sequencer state appears at the ports within one data field. Data may be forwarded from the wrong sector, the done pulse may be missing, or a status byte may be wrong when done rises. A miscounted deadline shows up at the exact boundary cycle. Acknowledging on the last allowed cycle must still finish cleanly, and one cycle later must give an overrun, in both densities. A wrong byte counter shows as a forwarded byte count that differs from DTL in the first short sector.

// File: rtl/srd_pkg.sv
// Shared types and status bit positions for the sector read engine.
// Assumes: status bit positions are decoded by host software and must not move.
package srd_pkg;
    typedef enum logic [2:0] {
        S_IDLE   = 3'd0,
        S_SEARCH = 3'd1,
        S_WAITD  = 3'd2,
        S_XFER   = 3'd3,
        S_SKIP   = 3'd4,
        S_DRAIN  = 3'd5
    } srd_state_t;

    localparam int ST1_DE = 5;   // data error
    localparam int ST1_OR = 4;   // overrun
    localparam int ST1_ND = 2;   // no data
    localparam int ST2_CM = 6;   // control mark
    localparam int ST2_DD = 5;   // error in data field
    localparam logic [1:0] IC_NORMAL = 2'b00;
    localparam logic [1:0] IC_ABNORM = 2'b01;
endpackage

// File: rtl/srd_host_port.sv
// Single-byte host holding register with a service deadline counter.
// The counter loads on every new byte and on every acknowledge. It
// decrements while a byte waits, and signals overrun when it reaches zero.
// Assumes: a new byte never arrives while the previous one still waits
// unless the command is already terminating (flush).
module srd_host_port #(
    parameter int FM_TICKS  = 27,
    parameter int MFM_TICKS = 13
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mfm,
    input  logic       load,
    input  logic [7:0] load_data,
    input  logic       ack,
    input  logic       flush,
    output logic       valid,
    output logic [7:0] data,
    output logic       overrun
);
    localparam int MAXT = (FM_TICKS > MFM_TICKS) ? FM_TICKS : MFM_TICKS;
    localparam int CW   = $clog2(MAXT + 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] reload;

    // Deadline selected by the latched density.
    assign reload = mfm ? CW'(MFM_TICKS) : CW'(FM_TICKS);

    // Holding register, valid flag and deadline counter.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            valid <= 1'b0;
            data  <= 8'h00;
            cnt   <= '0;
        end else if (load) begin
            valid <= 1'b1;
            data  <= load_data;
            cnt   <= reload;
        end else if (valid && ack) begin
            valid <= 1'b0;
            cnt   <= reload;
        end else if (valid && cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    // Deadline expired with a byte still waiting.
    assign overrun = valid && (cnt == '0);

    a_r10_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(MAXT));
    a_r10_ack_frees: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && ack && !load && !flush) |=> !valid);
    a_r2_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !load && !flush && !ack) |=> $stable(data));
endmodule

// File: rtl/srd_byte_gate.sv
// Counts the bytes of the current data field and decides whether each is
// forwarded. With a zero size code only the first DTL bytes pass.
// Assumes: clear coincides with the data field start strobe.
module srd_byte_gate #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             byte_in,
    input  logic             size_zero,
    input  logic [CNT_W-1:0] dtl,
    output logic             fwd
);
    logic [CNT_W-1:0] cnt;

    // Byte position within the field, saturating at the top value.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt <= '0;
        end else if (byte_in && cnt != {CNT_W{1'b1}}) begin
            cnt <= cnt + 1'b1;
        end
    end

    // Forward unless a short sector has reached its transfer length.
    assign fwd = byte_in && (!size_zero || cnt < dtl);

    a_r3_dtl_limit: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd && size_zero) |-> (cnt < dtl));
endmodule

// File: rtl/srd_seq_fsm.sv
// Command sequencer: ID matching, index pulse counting, deleted mark handling,
// CRC verdicts, overrun and termination status.
// Assumes: stream strobes are single-cycle and at most one of them per cycle,
// apart from an index pulse that may coincide with an ID record.
module srd_seq_fsm
    import srd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_start,
    input  logic       cmd_mfm,
    input  logic       cmd_skip,
    input  logic [7:0] cmd_r,
    input  logic [2:0] cmd_n,
    input  logic [7:0] cmd_dtl,
    input  logic       idx_pulse,
    input  logic       id_valid,
    input  logic [7:0] id_r,
    input  logic       id_crc_ok,
    input  logic       dat_start,
    input  logic       dat_deleted,
    input  logic       dat_end,
    input  logic       dat_crc_ok,
    input  logic       host_valid,
    input  logic       overrun,
    output logic       xfer_en,
    output logic       term,
    output logic       mfm,
    output logic       size_zero,
    output logic [7:0] dtl,
    output logic       busy,
    output logic       done,
    output logic [7:0] st0,
    output logic [7:0] st1,
    output logic [7:0] st2
);
    srd_state_t state, nxt;
    logic       skip_q, del_q, del_n, idx_q, idx_n;
    logic [7:0] tgt_q, tgt_n;
    logic [7:0] acc1, acc2, acc1_n, acc2_n, fin1, fin2;

    // Next state, flag accumulation and termination decision.
    always_comb begin
        nxt    = state;
        term   = 1'b0;
        del_n  = del_q;
        idx_n  = idx_q;
        tgt_n  = tgt_q;
        acc1_n = acc1;
        acc2_n = acc2;
        fin1   = acc1;
        fin2   = acc2;
        unique case (state)
            S_IDLE: if (cmd_start) nxt = S_SEARCH;
            S_SEARCH: begin
                if (id_valid) begin
                    if (!id_crc_ok) begin
                        fin1[ST1_DE] = 1'b1;
                        term = 1'b1;
                    end else if (id_r == tgt_q) begin
                        nxt = S_WAITD;
                    end
                end else if (idx_pulse) begin
                    if (idx_q) begin
                        fin1[ST1_ND] = 1'b1;
                        term = 1'b1;
                    end else begin
                        idx_n = 1'b1;
                    end
                end
            end
            S_WAITD: if (dat_start) begin
                del_n = dat_deleted;
                nxt   = (dat_deleted && skip_q) ? S_SKIP : S_XFER;
            end
            S_SKIP: if (dat_end) begin
                tgt_n = tgt_q + 8'd1;
                nxt   = S_SEARCH;
            end
            S_XFER: begin
                if (overrun) begin
                    fin1[ST1_OR] = 1'b1;
                    term = 1'b1;
                end else if (dat_end) begin
                    if (!dat_crc_ok) begin
                        acc1_n[ST1_DE] = 1'b1;
                        acc2_n[ST2_DD] = 1'b1;
                    end else if (del_q) begin
                        acc2_n[ST2_CM] = 1'b1;
                    end
                    nxt = S_DRAIN;
                end
            end
            S_DRAIN: begin
                if (overrun) begin
                    fin1[ST1_OR] = 1'b1;
                    term = 1'b1;
                end else if (!host_valid) begin
                    term = 1'b1;
                end
            end
            default: nxt = S_IDLE;
        endcase
        if (term) nxt = S_IDLE;
    end

    // State, latched command options and status registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= S_IDLE;
            done      <= 1'b0;
            st0       <= 8'h00;
            st1       <= 8'h00;
            st2       <= 8'h00;
            mfm       <= 1'b0;
            skip_q    <= 1'b0;
            size_zero <= 1'b0;
            dtl       <= 8'h00;
            tgt_q     <= 8'h00;
            del_q     <= 1'b0;
            idx_q     <= 1'b0;
            acc1      <= 8'h00;
            acc2      <= 8'h00;
        end else begin
            state <= nxt;
            done  <= term;
            del_q <= del_n;
            idx_q <= idx_n;
            tgt_q <= tgt_n;
            acc1  <= acc1_n;
            acc2  <= acc2_n;
            if (term) begin
                st0 <= {((fin1 | fin2) != 8'h00) ? IC_ABNORM : IC_NORMAL, 6'b0};
                st1 <= fin1;
                st2 <= fin2;
            end
            if (state == S_IDLE && cmd_start) begin
                mfm       <= cmd_mfm;
                skip_q    <= cmd_skip;
                size_zero <= (cmd_n == 3'd0);
                dtl       <= cmd_dtl;
                tgt_q     <= cmd_r;
                del_q     <= 1'b0;
                idx_q     <= 1'b0;
                acc1      <= 8'h00;
                acc2      <= 8'h00;
            end
        end
    end

    assign xfer_en = (state == S_XFER);
    assign busy    = (state != S_IDLE);

    a_r11_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r11_ic_code: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ((st0[7:6] == IC_ABNORM) == ((st1 | st2) != 8'h00)));
    a_r5_nd_from_search: assert property (@(posedge clk) disable iff (!rst_n)
        (done && st1[ST1_ND]) |-> ($past(state) == S_SEARCH));
endmodule

// File: rtl/sector_read_engine.sv
// Top of the sector read execution engine: sequencer, byte gate and host port.
// Assumes: CLK_HZ is a whole multiple of 1 MHz; the read channel supplies
// bytes slower than the host service deadline.
module sector_read_engine #(
    parameter int CLK_HZ = 1_000_000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_start,
    input  logic       cmd_mfm,
    input  logic       cmd_skip,
    input  logic [7:0] cmd_r,
    input  logic [2:0] cmd_n,
    input  logic [7:0] cmd_dtl,
    input  logic       idx_pulse,
    input  logic       id_valid,
    input  logic [7:0] id_r,
    input  logic       id_crc_ok,
    input  logic       dat_start,
    input  logic       dat_deleted,
    input  logic       dat_byte_valid,
    input  logic [7:0] dat_byte,
    input  logic       dat_end,
    input  logic       dat_crc_ok,
    output logic       host_valid,
    output logic [7:0] host_data,
    input  logic       host_ack,
    output logic       busy,
    output logic       done,
    output logic [7:0] st0,
    output logic [7:0] st1,
    output logic [7:0] st2
);
    localparam int TICKS_PER_US = CLK_HZ / 1_000_000;
    localparam int FM_TICKS     = 27 * TICKS_PER_US;
    localparam int MFM_TICKS    = 13 * TICKS_PER_US;

    logic       xfer_en, term, mfm, size_zero, overrun, fwd;
    logic [7:0] dtl;

    srd_seq_fsm u_seq (
        .clk(clk), .rst_n(rst_n),
        .cmd_start(cmd_start), .cmd_mfm(cmd_mfm), .cmd_skip(cmd_skip),
        .cmd_r(cmd_r), .cmd_n(cmd_n), .cmd_dtl(cmd_dtl),
        .idx_pulse(idx_pulse), .id_valid(id_valid), .id_r(id_r),
        .id_crc_ok(id_crc_ok), .dat_start(dat_start),
        .dat_deleted(dat_deleted), .dat_end(dat_end),
        .dat_crc_ok(dat_crc_ok), .host_valid(host_valid),
        .overrun(overrun), .xfer_en(xfer_en), .term(term), .mfm(mfm),
        .size_zero(size_zero), .dtl(dtl), .busy(busy), .done(done),
        .st0(st0), .st1(st1), .st2(st2)
    );

    srd_byte_gate #(.CNT_W(8)) u_gate (
        .clk(clk), .rst_n(rst_n), .clear(dat_start),
        .byte_in(dat_byte_valid && xfer_en), .size_zero(size_zero),
        .dtl(dtl), .fwd(fwd)
    );

    srd_host_port #(.FM_TICKS(FM_TICKS), .MFM_TICKS(MFM_TICKS)) u_port (
        .clk(clk), .rst_n(rst_n), .mfm(mfm), .load(fwd),
        .load_data(dat_byte), .ack(host_ack), .flush(term),
        .valid(host_valid), .data(host_data), .overrun(overrun)
    );

    a_r1_idle_no_pending: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !host_valid);
endmodule

// File: tb/sim_sector_read_engine.sv
// Directed bench: one task per scenario, each checking its own results.
module sim_sector_read_engine;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_start = 0, cmd_mfm = 0, cmd_skip = 0;
    logic [7:0] cmd_r = 0, cmd_dtl = 0;
    logic [2:0] cmd_n = 0;
    logic       idx_pulse = 0, id_valid = 0, id_crc_ok = 0;
    logic [7:0] id_r = 0;
    logic       dat_start = 0, dat_deleted = 0, dat_byte_valid = 0;
    logic [7:0] dat_byte = 0;
    logic       dat_end = 0, dat_crc_ok = 0;
    logic       host_valid, host_ack = 0;
    logic [7:0] host_data;
    logic       busy, done;
    logic [7:0] st0, st1, st2;

    int checks = 0, errors = 0;
    int host_en = 1, host_delay = 1, wait_cnt = 0;
    logic [7:0] cap [0:255];
    int cap_n = 0, done_cnt = 0;
    logic [7:0] d0, d1, d2;

    always #(CLK_PERIOD/2) clk = ~clk;

    sector_read_engine u0 (
        .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_mfm(cmd_mfm),
        .cmd_skip(cmd_skip), .cmd_r(cmd_r), .cmd_n(cmd_n), .cmd_dtl(cmd_dtl),
        .idx_pulse(idx_pulse), .id_valid(id_valid), .id_r(id_r),
        .id_crc_ok(id_crc_ok), .dat_start(dat_start),
        .dat_deleted(dat_deleted), .dat_byte_valid(dat_byte_valid),
        .dat_byte(dat_byte), .dat_end(dat_end), .dat_crc_ok(dat_crc_ok),
        .host_valid(host_valid), .host_data(host_data), .host_ack(host_ack),
        .busy(busy), .done(done), .st0(st0), .st1(st1), .st2(st2)
    );

    // Host model: acknowledges after host_delay waiting cycles.
    initial forever begin
        @(negedge clk);
        if (host_valid && host_en != 0) begin
            if (wait_cnt == host_delay) begin
                if (cap_n < 256) cap[cap_n] = host_data;
                cap_n++;
                host_ack = 1;
                wait_cnt = 0;
            end else begin
                host_ack = 0;
                wait_cnt++;
            end
        end else begin
            host_ack = 0;
            wait_cnt = 0;
        end
    end

    // Done monitor: counts pulse cycles and captures status.
    initial forever begin
        @(negedge clk);
        if (done) begin
            done_cnt++;
            d0 = st0; d1 = st1; d2 = st2;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete (actual hung, expected finish)");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic start_cmd(input logic mf, input logic sk, input logic [7:0] r,
                             input logic [2:0] n, input logic [7:0] dl);
        @(negedge clk);
        cap_n = 0; done_cnt = 0;
        cmd_mfm = mf; cmd_skip = sk; cmd_r = r; cmd_n = n; cmd_dtl = dl;
        cmd_start = 1;
        @(negedge clk);
        cmd_start = 0;
        repeat (2) @(negedge clk);
    endtask

    task automatic send_idx();
        idx_pulse = 1; @(negedge clk); idx_pulse = 0;
        repeat (3) @(negedge clk);
    endtask

    task automatic send_id(input logic [7:0] r, input logic ok);
        id_valid = 1; id_r = r; id_crc_ok = ok; @(negedge clk);
        id_valid = 0;
        repeat (3) @(negedge clk);
    endtask

    task automatic send_data(input logic del, input int nb, input logic ok,
                             input logic [7:0] seed, input int gap);
        dat_start = 1; dat_deleted = del; @(negedge clk);
        dat_start = 0;
        repeat (2) @(negedge clk);
        for (int i = 0; i < nb; i++) begin
            dat_byte = seed + 8'(i * 3); dat_byte_valid = 1;
            @(negedge clk);
            dat_byte_valid = 0;
            repeat (gap - 1) @(negedge clk);
        end
        dat_end = 1; dat_crc_ok = ok; @(negedge clk);
        dat_end = 0;
    endtask

    task automatic wait_done();
        for (int i = 0; i < 3000 && done_cnt == 0; i++) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    task automatic chk_data(input string req, input int exp_n, input logic [7:0] seed);
        int bad = 0;
        chk(req, "byte count", cap_n, exp_n);
        for (int i = 0; i < exp_n && i < cap_n; i++)
            if (cap[i] !== seed + 8'(i * 3)) bad++;
        chk(req, "data mismatches", bad, 0);
    endtask

    task automatic chk_status(input string req, input int e0, input int e1, input int e2);
        chk("R11", "done pulse cycles", done_cnt, 1);
        chk(req, "st0", d0, e0);
        chk(req, "st1", d1, e1);
        chk(req, "st2", d2, e2);
    endtask

    task automatic t_reset();
        chk("R1", "busy", busy, 0);
        chk("R1", "done", done, 0);
        chk("R1", "host_valid", host_valid, 0);
        chk("R1", "st0|st1|st2", st0 | st1 | st2, 0);
    endtask

    task automatic t_match();  // R2
        host_en = 1; host_delay = 1;
        start_cmd(1, 0, 8'd7, 3'd1, 8'hFF);
        send_id(8'd3, 1);
        send_data(0, 6, 1, 8'h90, 4);
        send_id(8'd7, 1);
        send_data(0, 10, 1, 8'h10, 4);
        wait_done();
        chk_data("R2", 10, 8'h10);
        chk_status("R2", 8'h00, 8'h00, 8'h00);
    endtask

    task automatic t_short();  // R3
        host_en = 1; host_delay = 1;
        start_cmd(1, 0, 8'd2, 3'd0, 8'd5);
        send_id(8'd2, 1);
        send_data(0, 20, 1, 8'h40, 4);
        wait_done();
        chk_data("R3", 5, 8'h40);
        chk_status("R3", 8'h00, 8'h00, 8'h00);
        start_cmd(1, 0, 8'd2, 3'd0, 8'd3);
        send_id(8'd2, 1);
        send_data(0, 10, 0, 8'h50, 4);
        wait_done();
        chk_data("R3", 3, 8'h50);
        chk_status("R3", 8'h40, 8'h20, 8'h20);
    endtask

    task automatic t_long();  // R4
        host_en = 1; host_delay = 0;
        start_cmd(0, 0, 8'd9, 3'd2, 8'd4);
        send_id(8'd9, 1);
        send_data(0, 16, 1, 8'h01, 4);
        wait_done();
        chk_data("R4", 16, 8'h01);
        chk_status("R4", 8'h00, 8'h00, 8'h00);
    endtask

    task automatic t_index();  // R5
        start_cmd(1, 0, 8'd4, 3'd1, 8'hFF);
        send_id(8'd1, 1);
        send_idx();
        send_id(8'd2, 1);
        chk("R5", "busy after one index", busy, 1);
        send_idx();
        wait_done();
        chk_status("R5", 8'h40, 8'h04, 8'h00);
        start_cmd(1, 0, 8'd4, 3'd1, 8'hFF);
        send_idx();
        send_id(8'd4, 1);
        send_data(0, 3, 1, 8'h22, 4);
        wait_done();
        chk_data("R5", 3, 8'h22);
        chk_status("R5", 8'h00, 8'h00, 8'h00);
    endtask

    task automatic t_idcrc();  // R6
        start_cmd(1, 0, 8'd4, 3'd1, 8'hFF);
        send_id(8'd4, 0);
        wait_done();
        chk_status("R6", 8'h40, 8'h20, 8'h00);
    endtask

    task automatic t_datcrc();  // R7
        host_delay = 1;
        start_cmd(1, 0, 8'd6, 3'd1, 8'hFF);
        send_id(8'd6, 1);
        send_data(0, 4, 0, 8'h70, 4);
        wait_done();
        chk_data("R7", 4, 8'h70);
        chk_status("R7", 8'h40, 8'h20, 8'h20);
    endtask

    task automatic t_del_noskip();  // R8
        start_cmd(1, 0, 8'd5, 3'd1, 8'hFF);
        send_id(8'd5, 1);
        send_data(1, 6, 1, 8'hA0, 4);
        wait_done();
        chk_data("R8", 6, 8'hA0);
        chk_status("R8", 8'h40, 8'h00, 8'h40);
    endtask

    task automatic t_del_skip();  // R9
        start_cmd(1, 1, 8'd5, 3'd1, 8'hFF);
        send_id(8'd5, 1);
        send_data(1, 8, 0, 8'hB0, 4);
        chk("R9", "bytes from skipped field", cap_n, 0);
        send_id(8'd5, 1);
        send_data(0, 3, 1, 8'hE0, 4);
        chk("R9", "bytes after same id again", cap_n, 0);
        send_id(8'd6, 1);
        send_data(0, 4, 1, 8'hC0, 4);
        wait_done();
        chk_data("R9", 4, 8'hC0);
        chk_status("R9", 8'h00, 8'h00, 8'h00);
    endtask

    task automatic t_service(input logic mf, input int dly, input int en,
                             input int exp1, input string what);  // R10
        host_en = en; host_delay = dly;
        start_cmd(mf, 0, 8'd3, 3'd1, 8'hFF);
        send_id(8'd3, 1);
        send_data(0, 3, 1, 8'h33, 40);
        wait_done();
        chk("R10", what, d1, exp1);
        chk("R10", "st0", d0, (exp1 != 0) ? 8'h40 : 8'h00);
        host_en = 1; host_delay = 1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_match();
        t_short();
        t_long();
        t_index();
        t_idcrc();
        t_datcrc();
        t_del_noskip();
        t_del_skip();
        t_service(1, 12, 1, 8'h00, "MFM ack on last cycle");
        t_service(1, 13, 1, 8'h10, "MFM ack one cycle late");
        t_service(0, 26, 1, 8'h00, "FM ack on last cycle");
        t_service(0, 0, 0, 8'h10, "FM no ack");
        chk("R1", "host_valid when idle", host_valid, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule